// File: doc/BRIEF.md
# EPROM Program-and-Verify Sequencer

This controller writes a byte-wide one-time-programmable memory with an adaptive routine. It visits every address in ascending order. At each address it gives a program strobe, reads the byte back, and gives more strobes until the read-back equals the intended byte or the pulse budget for that address runs out. When the last address is done, it drops the supply to the nominal condition and reads the whole array a second time. Any mismatch in that second pass ends the run as failed.

A host pulses `start`. The sequencer then presents each address on `mem_addr` and takes the intended byte for that address from `src_data`, which the data source drives combinationally from `mem_addr`. The memory side is driven through active-low chip-enable, output-enable and program strobes, a data drive enable, and two mode outputs. `vpp_en` enables the programming voltage, and `supply_hi` selects the elevated supply instead of the nominal one. At the end of the run `done` pulses for one cycle together with the verdict. `pass` and `fail` keep their values until the next accepted start. `fail_addr` holds the address where a failed run stopped.

The controller is one state machine with seven states. ST_IDLE goes to ST_PSET on start. ST_PSET is the setup gap and goes to ST_PULSE. ST_PULSE is the strobe and goes to ST_PHOLD. ST_PHOLD is the hold gap and goes to ST_VREAD. ST_VREAD is the verify read. From ST_VREAD the machine takes one of four transitions. A match at an address before the last goes to ST_PSET with the address advanced. A match at the last address goes to ST_FREAD at address 0. A mismatch with budget left goes back to ST_PSET at the same address. A mismatch with the budget spent goes to ST_DONE as failed. ST_FREAD is the final read, one address per window. It advances the address on a match. On a mismatch, or after a match at the last address, it goes to ST_DONE. ST_DONE returns to ST_IDLE after one cycle.

Top module: `eprom_prog_seq`

## Requirements
- R1: While reset is active and right after it, done, pass and fail are 0, mem_ce_n, mem_oe_n and mem_pgm_n are 1, and vpp_en, supply_hi and mem_dq_oe are 0.
- R2: During a program pulse, mem_ce_n=0, mem_pgm_n=0, mem_oe_n=1, vpp_en=1 and mem_dq_oe=1, with mem_dout equal to src_data. Each pulse lasts exactly PULSE_CYC cycles.
- R3: Each pulse is followed by HOLD_CYC cycles and then one verify read of the same address. The read lasts READ_CYC cycles with mem_ce_n=0, mem_oe_n=0, mem_pgm_n=1 and mem_dq_oe=0. The read-back is compared with src_data in the last cycle of the read. The number of verify reads equals the number of pulses.
- R4: An address gets pulses until its read-back matches, up to MAX_PULSES pulses. A match on the MAX_PULSES-th pulse counts as a success.
- R5: Addresses are programmed in ascending order from 0 to 2^ADDR_W-1. supply_hi=1 throughout the per-address phase.
- R6: After the last address matches, every address is read once more in ascending order with supply_hi=0 and vpp_en=0. No pulse is given in this pass.
- R7: If MAX_PULSES pulses fail to give a match, the run ends with done, fail=1, pass=0 and fail_addr set to that address. No higher address gets a pulse.
- R8: If a mismatch occurs in the final pass, the run ends at the first mismatching address with fail=1 and fail_addr set to that address.
- R9: A clean run ends with pass=1 and fail=0 in the same cycle as done. pass and fail keep their values until an accepted start clears them.
- R10: Let n_a be the number of pulses at address a, C = SETUP_CYC+PULSE_CYC+HOLD_CYC+READ_CYC, and N = 2^ADDR_W. For a clean run, counting clock edges from the edge that accepts start, done is first seen high after sum(n_a)*C + N*READ_CYC + 1 edges.
- R11: start is ignored while a run is in progress, so neither the result nor the timing changes. done is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run completed cleanly |
| fail | output | 1 | Last run failed |
| fail_addr | output | ADDR_W | Address at which a failed run stopped |
| src_data | input | DATA_W | Intended byte for the current mem_addr |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Data driven to the memory while programming |
| mem_dq_oe | output | 1 | Data drive enable toward the memory |
| mem_din | input | DATA_W | Data read back from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |
| vpp_en | output | 1 | Programming voltage enable |
| supply_hi | output | 1 | 1 selects the elevated supply, 0 the nominal supply |

## Verification
Two conditions can be decided in the same verify read: the pulse budget becomes exhausted, and the byte finally matches. When both happen the match must win. The bench provokes this by modelling an address that needs exactly MAX_PULSES pulses before it reads back correctly, and it judges the case by requiring a pass verdict, the full pulse count at that address, and programming that carries on to the next address. The neighbouring case, one pulse more than the budget, must give a fail at that address with no pulses above it.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PSET,
        ST_PULSE,
        ST_PHOLD,
        ST_VREAD,
        ST_FREAD,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/seq_addr_ctr.sv
module seq_addr_ctr #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr <= '0;
        else if (clr)
            addr <= '0;
        else if (inc)
            addr <= addr + 1'b1;
    end

    assign last = &addr;
endmodule

// File: rtl/seq_pulse_ctr.sv
module seq_pulse_ctr #(
    parameter int MAX_PULSES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int PW = $clog2(MAX_PULSES + 1);
    localparam logic [PW-1:0] LIMIT = PW'(MAX_PULSES);

    logic [PW-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (clr)
            pcnt <= '0;
        else if (inc && pcnt != LIMIT)
            pcnt <= pcnt + 1'b1;
    end

    assign at_limit = (pcnt == LIMIT);
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
    import eprom_seq_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int DATA_W     = 8,
    parameter int MAX_PULSES = 25,
    parameter int SETUP_CYC  = 2,
    parameter int PULSE_CYC  = 10,
    parameter int HOLD_CYC   = 2,
    parameter int READ_CYC   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    input  logic [DATA_W-1:0] src_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_pgm_n,
    output logic              vpp_en,
    output logic              supply_hi
);
    localparam int TMAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int TMAX_B = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
    localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int TW     = $clog2(TMAX + 1);
    localparam logic [TW-1:0] T_SETUP = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] T_PULSE = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] T_HOLD  = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] T_READ  = TW'(READ_CYC - 1);

    seq_state_t state, state_nx;

    logic          tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    logic          addr_clr, addr_inc, addr_last;
    logic          pc_clr, pc_inc, pc_limit;
    logic          set_pass, set_fail, accept;
    logic          match;

    logic              pass_q, fail_q;
    logic [ADDR_W-1:0] fail_addr_q;

    seq_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    seq_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (addr_clr),
        .inc   (addr_inc),
        .addr  (mem_addr),
        .last  (addr_last)
    );

    seq_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pulses (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pc_clr),
        .inc      (pc_inc),
        .at_limit (pc_limit)
    );

    assign match = (mem_din == src_data);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Transitions and counter controls
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        addr_clr = 1'b0;
        addr_inc = 1'b0;
        pc_clr   = 1'b0;
        pc_inc   = 1'b0;
        set_pass = 1'b0;
        set_fail = 1'b0;
        accept   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    accept   = 1'b1;
                    state_nx = ST_PSET;
                    tmr_load = 1'b1;
                    tmr_val  = T_SETUP;
                    addr_clr = 1'b1;
                    pc_clr   = 1'b1;
                end
            end
            ST_PSET: begin
                if (tmr_done) begin
                    state_nx = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = T_PULSE;
                end
            end
            ST_PULSE: begin
                if (tmr_done) begin
                    state_nx = ST_PHOLD;
                    tmr_load = 1'b1;
                    tmr_val  = T_HOLD;
                    pc_inc   = 1'b1;
                end
            end
            ST_PHOLD: begin
                if (tmr_done) begin
                    state_nx = ST_VREAD;
                    tmr_load = 1'b1;
                    tmr_val  = T_READ;
                end
            end
            ST_VREAD: begin
                if (tmr_done) begin
                    if (match && addr_last) begin
                        state_nx = ST_FREAD;
                        tmr_load = 1'b1;
                        tmr_val  = T_READ;
                        addr_clr = 1'b1;
                    end else if (match) begin
                        state_nx = ST_PSET;
                        tmr_load = 1'b1;
                        tmr_val  = T_SETUP;
                        addr_inc = 1'b1;
                        pc_clr   = 1'b1;
                    end else if (pc_limit) begin
                        state_nx = ST_DONE;
                        set_fail = 1'b1;
                    end else begin
                        state_nx = ST_PSET;
                        tmr_load = 1'b1;
                        tmr_val  = T_SETUP;
                    end
                end
            end
            ST_FREAD: begin
                if (tmr_done) begin
                    if (!match) begin
                        state_nx = ST_DONE;
                        set_fail = 1'b1;
                    end else if (addr_last) begin
                        state_nx = ST_DONE;
                        set_pass = 1'b1;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = T_READ;
                        addr_inc = 1'b1;
                    end
                end
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Memory-side strobes and supply mode
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_pgm_n = 1'b1;
        mem_dq_oe = 1'b0;
        vpp_en    = 1'b0;
        supply_hi = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_PSET, ST_PHOLD: begin
                mem_ce_n  = 1'b0;
                mem_dq_oe = 1'b1;
                vpp_en    = 1'b1;
                supply_hi = 1'b1;
            end
            ST_PULSE: begin
                mem_ce_n  = 1'b0;
                mem_pgm_n = 1'b0;
                mem_dq_oe = 1'b1;
                vpp_en    = 1'b1;
                supply_hi = 1'b1;
            end
            ST_VREAD: begin
                mem_ce_n  = 1'b0;
                mem_oe_n  = 1'b0;
                vpp_en    = 1'b1;
                supply_hi = 1'b1;
            end
            ST_FREAD: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign mem_dout = src_data;

    // Verdict flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_q      <= 1'b0;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
        end else if (accept) begin
            pass_q <= 1'b0;
            fail_q <= 1'b0;
        end else if (set_fail) begin
            fail_q      <= 1'b1;
            fail_addr_q <= mem_addr;
        end else if (set_pass) begin
            pass_q <= 1'b1;
        end
    end

    assign pass      = pass_q;
    assign fail      = fail_q;
    assign fail_addr = fail_addr_q;
endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic pass,
    input logic fail,
    input logic mem_ce_n,
    input logic mem_oe_n,
    input logic mem_pgm_n,
    input logic mem_dq_oe,
    input logic vpp_en,
    input logic supply_hi
);
    // R2
    pulse_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_pgm_n |-> (!mem_ce_n && mem_oe_n && vpp_en && mem_dq_oe));

    // R3
    read_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dq_oe && mem_pgm_n && !mem_ce_n));

    // R6
    nominal_nopulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_hi |-> (mem_pgm_n && !vpp_en && !mem_dq_oe));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass != fail));

    // R9
    pass_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass) |-> done);

    // R7
    fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> done);
endmodule

bind eprom_prog_seq eprom_prog_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .pass      (pass),
    .fail      (fail),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_pgm_n (mem_pgm_n),
    .mem_dq_oe (mem_dq_oe),
    .vpp_en    (vpp_en),
    .supply_hi (supply_hi)
);

// File: tb/sim_eprom_prog_seq.sv
module sim_eprom_prog_seq;
    localparam int AW  = 3;
    localparam int DW  = 8;
    localparam int N   = 1 << AW;
    localparam int MXP = 4;
    localparam int SC  = 1;
    localparam int PC  = 3;
    localparam int HC  = 2;
    localparam int RC  = 2;
    localparam int CYC = SC + PC + HC + RC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          done, pass, fail;
    logic [AW-1:0] fail_addr, mem_addr;
    logic [DW-1:0] src_data, mem_dout, mem_din;
    logic          mem_dq_oe, mem_ce_n, mem_oe_n, mem_pgm_n, vpp_en, supply_hi;

    int checks = 0;
    int errors = 0;

    int          need   [N];
    int          pcount [N];
    logic [DW-1:0] prog [N];
    logic [DW-1:0] pattern [N];
    int          bad_addr = -1;
    int          viol_strobe = 0;
    int          viol_order  = 0;
    int          viol_width  = 0;
    int          viol_final  = 0;
    int          vreads      = 0;
    int          last_paddr  = 0;
    int          lowcnt      = 0;
    int          cycles      = 0;

    always #10 clk = ~clk;

    eprom_prog_seq #(
        .ADDR_W(AW), .DATA_W(DW), .MAX_PULSES(MXP),
        .SETUP_CYC(SC), .PULSE_CYC(PC), .HOLD_CYC(HC), .READ_CYC(RC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
        .fail(fail), .fail_addr(fail_addr), .src_data(src_data),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dq_oe(mem_dq_oe),
        .mem_din(mem_din), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_pgm_n(mem_pgm_n), .vpp_en(vpp_en), .supply_hi(supply_hi)
    );

    assign src_data = pattern[mem_addr];

    // Memory model: a cell reads erased until it has had enough pulses
    always_comb begin
        mem_din = '0;
        if (!mem_ce_n && !mem_oe_n) begin
            if (pcount[mem_addr] >= need[mem_addr])
                mem_din = prog[mem_addr];
            else
                mem_din = 8'hFF;
            if (!supply_hi && int'(mem_addr) == bad_addr)
                mem_din = ~prog[mem_addr];
        end
    end

    always @(negedge mem_pgm_n) begin
        if (rst_n) begin
            pcount[mem_addr] = pcount[mem_addr] + 1;
            prog[mem_addr]   = mem_dout;
            if (mem_ce_n || !mem_oe_n || !vpp_en || !supply_hi || !mem_dq_oe
                || mem_dout != pattern[mem_addr])
                viol_strobe++;
            if (int'(mem_addr) < last_paddr)
                viol_order++;
            last_paddr = int'(mem_addr);
        end
    end

    always @(negedge mem_oe_n) begin
        if (rst_n && supply_hi) vreads++;
    end

    always @(posedge clk) begin
        cycles++;
        if (!mem_pgm_n) lowcnt++;
        else if (lowcnt != 0) begin
            if (lowcnt != PC) viol_width++;
            lowcnt = 0;
        end
        if (rst_n && !supply_hi && (!mem_pgm_n || vpp_en)) viol_final++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // mode 0: clean; mode 1: pulse-limit fail at addr f; mode 2: final mismatch at f
    task automatic run_case(input int mode, input int f, input bit poke_start);
        int t;
        int exp_cyc;
        int exp_pc [N];
        int psum;
        int cyc;
        int bad_pc;
        for (int a = 0; a < N; a++) begin
            pcount[a] = 0;
            prog[a]   = 8'hFF;
        end
        bad_addr    = (mode == 2) ? f : -1;
        viol_strobe = 0; viol_order = 0; viol_width = 0; viol_final = 0;
        vreads = 0; last_paddr = 0;
        psum = 0;
        for (int a = 0; a < N; a++) begin
            if (mode == 1 && a > f) exp_pc[a] = 0;
            else if (mode == 1 && a == f) exp_pc[a] = MXP;
            else exp_pc[a] = need[a];
            psum += exp_pc[a];
        end
        if (mode == 0) exp_cyc = psum * CYC + N * RC + 1;
        else if (mode == 1) exp_cyc = psum * CYC + 1;
        else exp_cyc = psum * CYC + (f + 1) * RC + 1;

        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R9 flags cleared by start (pass)", int'(pass), 0);
        check("R9 flags cleared by start (fail)", int'(fail), 0);
        cyc = 1;
        t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            cyc++;
            t++;
            if (poke_start && cyc == 5)  start = 1'b1;
            if (poke_start && cyc == 7)  start = 1'b0;
            if (poke_start && cyc == 40) start = 1'b1;
            if (poke_start && cyc == 41) start = 1'b0;
        end
        start = 1'b0;
        check(poke_start ? "R11 timing with start while busy" : "R10 cycles to done",
              cyc, exp_cyc);
        check(mode == 0 ? "R9 pass with done" : "R7/R8 pass low", int'(pass), mode == 0 ? 1 : 0);
        check(mode == 1 ? "R7 fail flag" : (mode == 2 ? "R8 fail flag" : "R9 fail low"),
              int'(fail), mode == 0 ? 0 : 1);
        if (mode != 0)
            check(mode == 1 ? "R7 fail_addr" : "R8 fail_addr", int'(fail_addr), f);
        bad_pc = 0;
        for (int a = 0; a < N; a++)
            if (pcount[a] != exp_pc[a]) begin
                bad_pc++;
                $display("  addr %0d pulses actual %0d expected %0d", a, pcount[a], exp_pc[a]);
            end
        check(mode == 1 ? "R7 pulses per address" : "R4 pulses per address", bad_pc, 0);
        check("R2 strobe levels and data", viol_strobe, 0);
        check("R2 pulse width", viol_width, 0);
        check("R5 ascending address order", viol_order, 0);
        check("R3 one verify read per pulse", vreads, psum);
        check("R6 no pulse under nominal supply", viol_final, 0);
        @(negedge clk);
        check("R11 done single cycle", int'(done), 0);
        check("R9 verdict held after done", int'(pass) + 2 * int'(fail),
              mode == 0 ? 1 : 2);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int a = 0; a < N; a++) begin
            pattern[a] = DW'((a * 37 + 5) & 8'h7F);
            need[a]    = (a % MXP) + 1;
            pcount[a]  = 0;
            prog[a]    = 8'hFF;
        end
        // R1
        repeat (2) @(negedge clk);
        check("R1 done in reset", int'(done), 0);
        check("R1 pass/fail in reset", int'(pass) + int'(fail), 0);
        check("R1 strobes idle in reset", int'({mem_ce_n, mem_oe_n, mem_pgm_n}), 7);
        check("R1 supply outputs in reset", int'({vpp_en, supply_hi, mem_dq_oe}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 strobes idle after reset", int'({mem_ce_n, mem_oe_n, mem_pgm_n, vpp_en}), 14);

        // R4 clean run; addresses 3 and 7 need exactly the pulse limit
        run_case(0, 0, 1'b0);

        // R7 one pulse beyond the limit at several addresses
        for (int f = 0; f < N; f += 3) begin
            for (int a = 0; a < N; a++) need[a] = (a % MXP) + 1;
            need[f] = MXP + 1;
            run_case(1, f, 1'b0);
        end

        // R8 final-pass mismatch at each address
        for (int a = 0; a < N; a++) need[a] = ((a + 1) % 2) + 1;
        for (int f = 0; f < N; f++) run_case(2, f, 1'b0);

        // R11 start pulses during a clean run
        for (int a = 0; a < N; a++) need[a] = 1;
        run_case(0, 0, 1'b1);

        // R4 every address needs exactly the limit
        for (int a = 0; a < N; a++) need[a] = MXP;
        run_case(0, 0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule